// File: doc/BRIEF.md
# Independent Receive/Transmit Chain Enable Controller

This block runs a small two-state radio controller (ALERT and full duplex) in the feedback-clock domain. Register writes are the only way it moves between its two states. While it sits in full duplex and the independent-control option is on, the two external control pins stop acting as state-machine controls. They become a receive-on request and a transmit-on request, each driving its own chain enable. The controller never leaves full duplex on its own and has no flush phase. The external baseband controller must wait for filters to drain and transmissions to finish before it drops a chain.

A mode input selects how the pins are read. In level mode each synchronized pin drives its chain enable directly. In pulse mode a rising edge on a pin flips its chain's enable, however long the pin is then held high. The transmit data path is gated by the frame signal: while the frame is low, zeros go out.

Top module: `fdd_chain_ctrl`

## Requirements
- R1: After reset the state code is ALERT (4'h5), both chain enables are 0, the equivalent-state output is 0 and the transmit data output is all zeros.
- R2: A write (wr_valid_i high with wr_fdd_i high) moves the state code to full duplex (4'hA) at the next clock edge. Pin activity never changes the state code.
- R3: A write with wr_fdd_i low returns the state code to ALERT. Both enables are 0 from the edge after it, and any pulse-mode toggle state is gone, so a later re-entry starts with both chains off.
- R4: While the state is ALERT, both enables stay 0 whatever the pins, the mode and the option bit do.
- R5: In full duplex, with the option bit set and level mode selected (pulse_mode_i low), rx_en_o follows pin_rx_i and tx_en_o follows pin_tx_i. Each pin change shows on its enable at the third clock edge after it is applied (two synchronizer stages plus the enable register).
- R6: In full duplex, with the option bit set and pulse mode selected (pulse_mode_i high), each rising edge on a pin inverts that chain's enable exactly once, at the third edge after the rise. A pin held high for any number of cycles gives one inversion. Falling edges change nothing. A one-cycle-wide pulse is enough.
- R7: When full duplex is entered from ALERT in pulse mode, both chains are off until a rising edge arrives. A pin that is already high at entry does not count as an edge.
- R8: In full duplex with the option bit clear, both enables are 1 from the edge after the state is entered, and the pins have no effect.
- R9: tx_data_o is a register. One edge after a cycle in which tx_frame_i is low it holds zeros. One edge after a cycle in which tx_frame_i is high it holds that cycle's tx_data_i.
- R10: equiv_o encodes the chain enables as {tx_en_o, rx_en_o}: 0 means both off (ALERT-like), 1 means receive only, 2 means transmit only, 3 means both on (full-duplex-like).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Feedback clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| indep_en_i | input | 1 | Independent chain control option bit |
| pulse_mode_i | input | 1 | 1 selects pulse mode, 0 selects level mode |
| wr_valid_i | input | 1 | Register write strobe for the state |
| wr_fdd_i | input | 1 | Target state of the write: 1 full duplex, 0 ALERT |
| pin_rx_i | input | 1 | Asynchronous receive control pin |
| pin_tx_i | input | 1 | Asynchronous transmit control pin |
| tx_frame_i | input | 1 | Transmit frame qualifier |
| tx_data_i | input | DW | Transmit data in |
| rx_en_o | output | 1 | Receive chain enable |
| tx_en_o | output | 1 | Transmit chain enable |
| state_o | output | 4 | State code (4'h5 ALERT, 4'hA full duplex) |
| equiv_o | output | 2 | Equivalent-state code |
| tx_data_o | output | DW | Gated transmit data out |

## Verification
Pin stimulus affects a chain enable at the third rising edge after it is driven. A state write shows on the state code at the first edge, and on the enables one edge later. The gated transmit data is due one edge after its inputs. All stimulus is applied on the falling edge, and the bench waits exactly the matching number of rising edges before sampling at the next falling edge. The latency check for level mode also samples after only two edges to confirm the enable has not yet moved. The pulse-mode tests check, at those same sample points, that a held pin, a falling edge and a pin already high at entry each leave the enable unchanged.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [3:0] {
    ST_ALERT = 4'h5,
    ST_FDD   = 4'hA
  } fcc_state_e;

  localparam int unsigned NCHAIN = 2;
  localparam int unsigned CH_RX  = 0;
  localparam int unsigned CH_TX  = 1;
endpackage

// File: rtl/fcc_sync.sv
module fcc_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fcc_chain.sv
module fcc_chain (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic in_fdd_i,
  input  logic indep_i,
  input  logic pulse_mode_i,
  output logic en_o
);
  logic prev_q;
  logic rise;
  logic en_q, en_d;

  assign rise = lvl_i & ~prev_q;

  always_comb begin
    if (!in_fdd_i)         en_d = 1'b0;
    else if (!indep_i)     en_d = 1'b1;
    else if (pulse_mode_i) en_d = rise ? ~en_q : en_q;
    else                   en_d = lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      en_q   <= en_d;
    end
  end

  assign en_o = en_q;

  p_alert_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_fdd_i |=> !en_q);
  p_level_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fdd_i && indep_i && !pulse_mode_i) |=> (en_q == $past(lvl_i)));
  p_pulse_flip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fdd_i && indep_i && pulse_mode_i && rise) |=> (en_q != $past(en_q)));
  p_pulse_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fdd_i && indep_i && pulse_mode_i && !rise) |=> $stable(en_q));
  p_single_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !rise);
  p_opt_clear_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fdd_i && !indep_i) |=> en_q);
endmodule

// File: rtl/fcc_tx_gate.sv
module fcc_tx_gate #(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] data_q, data_d;

  always_comb data_d = frame_i ? data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_d;
  end

  assign data_o = data_q;

  p_zero_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> (data_o == '0));
  p_pass_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (data_o == $past(data_i)));
endmodule

// File: rtl/fdd_chain_ctrl.sv
module fdd_chain_ctrl
  import fcc_pkg::*;
#(
  parameter int unsigned DW          = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          indep_en_i,
  input  logic          pulse_mode_i,
  input  logic          wr_valid_i,
  input  logic          wr_fdd_i,
  input  logic          pin_rx_i,
  input  logic          pin_tx_i,
  input  logic          tx_frame_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          rx_en_o,
  output logic          tx_en_o,
  output logic [3:0]    state_o,
  output logic [1:0]    equiv_o,
  output logic [DW-1:0] tx_data_o
);
  fcc_state_e state_q, state_d;
  logic [NCHAIN-1:0] pins_raw, pins_sync, chain_en;
  logic in_fdd;

  always_comb begin
    state_d = state_q;
    if (wr_valid_i) state_d = wr_fdd_i ? ST_FDD : ST_ALERT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ALERT;
    else         state_q <= state_d;
  end

  assign in_fdd = (state_q == ST_FDD);

  assign pins_raw[CH_RX] = pin_rx_i;
  assign pins_raw[CH_TX] = pin_tx_i;

  fcc_sync #(.W(NCHAIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_sync)
  );

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    fcc_chain u_chain (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lvl_i        (pins_sync[c]),
      .in_fdd_i     (in_fdd),
      .indep_i      (indep_en_i),
      .pulse_mode_i (pulse_mode_i),
      .en_o         (chain_en[c])
    );
  end

  fcc_tx_gate #(.DW(DW)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (tx_frame_i),
    .data_i  (tx_data_i),
    .data_o  (tx_data_o)
  );

  assign rx_en_o = chain_en[CH_RX];
  assign tx_en_o = chain_en[CH_TX];
  assign state_o = state_q;
  assign equiv_o = {chain_en[CH_TX], chain_en[CH_RX]};

  p_legal_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ALERT) || (state_q == ST_FDD));
  p_enter_fdd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_fdd_i) |=> (state_o == ST_FDD));
  p_pins_no_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> $stable(state_o));
  p_leave_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wr_fdd_i) |=> ##1 (!rx_en_o && !tx_en_o));
endmodule

// File: tb/fdd_chain_ctrl_tb_top.sv
module fdd_chain_ctrl_tb_top;
  localparam int unsigned DW = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic indep, pmode, wr_v, wr_f, prx, ptx, frame;
  logic [DW-1:0] din, dout;
  logic rx_en, tx_en;
  logic [3:0] st;
  logic [1:0] eq;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fdd_chain_ctrl #(.DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .indep_en_i(indep), .pulse_mode_i(pmode),
    .wr_valid_i(wr_v), .wr_fdd_i(wr_f), .pin_rx_i(prx), .pin_tx_i(ptx),
    .tx_frame_i(frame), .tx_data_i(din), .rx_en_o(rx_en), .tx_en_o(tx_en),
    .state_o(st), .equiv_o(eq), .tx_data_o(dout)
  );

  // row: {indep, rx pin, tx pin, exp rx_en, exp tx_en}, level mode, full duplex
  localparam logic [4:0] VEC [0:7] = '{
    5'b1_00_00, 5'b1_10_10, 5'b1_01_01, 5'b1_11_11,
    5'b1_00_00, 5'b0_00_11, 5'b0_10_11, 5'b0_01_11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_state(input logic to_fdd);
    wr_v = 1'b1; wr_f = to_fdd;
    @(negedge clk);
    wr_v = 1'b0;
  endtask

  task automatic pulse_pin(input bit is_tx);
    if (is_tx) ptx = 1'b1; else prx = 1'b1;
    edges(1);
    if (is_tx) ptx = 1'b0; else prx = 1'b0;
    edges(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; indep = 1'b1; pmode = 1'b0; wr_v = 1'b0; wr_f = 1'b0;
    prx = 1'b0; ptx = 1'b0; frame = 1'b0; din = '0;
    edges(3);
    rst_n = 1'b1;
    edges(1);
    chk("R1 state", st, 4'h5);
    chk("R1 enables", {tx_en, rx_en}, 2'b00);
    chk("R1 equiv", eq, 2'd0);
    chk("R1 txdata", dout, '0);

    // ALERT: pins do nothing
    prx = 1'b1; ptx = 1'b1;
    edges(6);
    chk("R2 pins keep ALERT", st, 4'h5);
    chk("R4 enables off in ALERT", {tx_en, rx_en}, 2'b00);
    prx = 1'b0; ptx = 1'b0;
    edges(3);

    write_state(1'b1);
    chk("R2 enter full duplex", st, 4'hA);
    edges(3);

    for (int i = 0; i < 8; i++) begin
      indep = VEC[i][4]; prx = VEC[i][3]; ptx = VEC[i][2];
      edges(3);
      if (VEC[i][4]) chk($sformatf("R5 level row %0d", i), {tx_en, rx_en}, {VEC[i][0], VEC[i][1]});
      else           chk($sformatf("R8 option clear row %0d", i), {tx_en, rx_en}, {VEC[i][0], VEC[i][1]});
      chk($sformatf("R10 equiv row %0d", i), eq, {VEC[i][0], VEC[i][1]});
      chk($sformatf("R2 pins row %0d", i), st, 4'hA);
    end

    // level latency
    indep = 1'b1; prx = 1'b0; ptx = 1'b0;
    edges(3);
    prx = 1'b1;
    edges(2);
    chk("R5 not yet after 2 edges", rx_en, 1'b0);
    edges(1);
    chk("R5 due after 3 edges", rx_en, 1'b1);

    // leave to ALERT, re-enter in pulse mode with rx pin held high
    write_state(1'b0);
    chk("R3 state ALERT", st, 4'h5);
    edges(1);
    chk("R3 enables off", {tx_en, rx_en}, 2'b00);
    pmode = 1'b1;
    write_state(1'b1);
    edges(3);
    chk("R7 off at entry with pin high", {tx_en, rx_en}, 2'b00);
    prx = 1'b0;
    edges(3);
    chk("R6 falling edge ignored", {tx_en, rx_en}, 2'b00);
    pulse_pin(1'b0);
    chk("R6 rx toggled on", {tx_en, rx_en}, 2'b01);
    ptx = 1'b1;
    edges(8);
    chk("R6 held pin one toggle", {tx_en, rx_en}, 2'b11);
    chk("R10 equiv both", eq, 2'd3);
    ptx = 1'b0;
    edges(3);
    chk("R6 release no effect", {tx_en, rx_en}, 2'b11);
    pulse_pin(1'b0);
    chk("R6 rx toggled off", {tx_en, rx_en}, 2'b10);
    chk("R10 equiv tx only", eq, 2'd2);

    write_state(1'b0);
    edges(1);
    chk("R3 off after leave", {tx_en, rx_en}, 2'b00);
    write_state(1'b1);
    edges(3);
    chk("R3 toggle state cleared", {tx_en, rx_en}, 2'b00);
    chk("R2 back in full duplex", st, 4'hA);

    // transmit data gating
    din = 12'hABC; frame = 1'b0;
    edges(1);
    chk("R9 frame low zeros", dout, 12'h000);
    frame = 1'b1;
    edges(1);
    chk("R9 frame high pass", dout, 12'hABC);
    din = 12'h123;
    edges(1);
    chk("R9 new data pass", dout, 12'h123);
    frame = 1'b0;
    edges(1);
    chk("R9 frame drop zeros", dout, 12'h000);

    finish_run();
  end
endmodule